// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a small configuration space reached through a pair of byte-wide I/O ports. The host writes a register number to the index port and then reads or writes that register through the data port. The space stays closed until a two-byte unlock key arrives on the index port. A separate key closes it again. Stray traffic on the bus therefore cannot change the configuration by accident.

Inside the space, one global register picks a logical device. Each logical device has its own bank. A bank holds an enable flag, a 16-bit base address and an interrupt line number. The bank contents drive output pins so that neighbouring decode logic can use them.

Two global registers return a fixed chip identifier and two more return a vendor identifier. A strap input chooses which of two I/O address pairs the block answers on. All reads are registered and appear on `rdata` one cycle after the read strobe.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the space is closed, the index and device-select registers are 0, every bank's enable, base and interrupt outputs are 0, and `rdata` is 0xFF.
- R2: The space opens only after two consecutive index-port writes of 0x87. If any other index-port write comes between them, the sequence restarts. After a single 0x87, data-port reads return 0xFF.
- R3: An index-port write of 0xAA while open closes the space. While closed, data-port and index-port reads return 0xFF and data-port writes change nothing.
- R4: While open, an index-port write loads the index register, a data-port access reaches the register that the index names, and an index-port read returns the current index. The index keeps its value while the space is closed.
- R5: Register 0x07 holds the device number and reads back as written. Per-device registers always reach the bank that the device number selects, and other banks are untouched.
- R6: Each bank has four registers. Bit 0 of register 0x30 is the enable and reads back zero-extended. Registers 0x60 and 0x61 are the high and low bytes of the base address. The low IRQ_W bits of register 0x70 are the interrupt number and read back zero-extended. These values drive `dev_enable[d]`, `dev_base[16d+15:16d]` and `dev_irq[IRQ_W*d+IRQ_W-1:IRQ_W*d]`.
- R7: Registers 0x20/0x21 return the high and low bytes of CHIP_ID (default 0x5A21), and 0x23/0x24 return those of VENDOR_ID (default 0x1C34). Writes to them are ignored.
- R8: With `strap_alt`=0 the index/data ports are 0x2E/0x2F, and with `strap_alt`=1 they are 0x4E/0x4F. Reads of the inactive pair return 0xFF, and writes to it are ignored, including key bytes.
- R9: When the device number is NUM_DEV or above, per-device registers read 0xFF and writes to them are ignored.
- R10: `rdata` is loaded on the clock edge that samples `rd_en` and holds between reads. A read of any address other than the active pair returns 0xFF. An open read of an unmapped register returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Selects the alternate index/data port pair |
| bus_addr | input | ADDR_W | I/O address of the current access |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| dev_enable | output | NUM_DEV | Per-device enable flags |
| dev_base | output | 16*NUM_DEV | Per-device base addresses, device 0 in the low bits |
| dev_irq | output | IRQ_W*NUM_DEV | Per-device interrupt numbers, device 0 in the low bits |

## Verification
The unlock logic is driven with four key patterns: a lone 0x87, 0x87 interrupted by another byte, a clean double 0x87, and 0xAA while open. Together they separate "opens after one key" from "opens after two", and "restarts" from "remembers a half key". Banked access is tried with one device in range, a second untouched device, and a device number outside the range. This shows whether writes really follow the device register or leak into another bank. The strap is then flipped while the space is open, to confirm that only the chosen address pair reacts and that a close key on the other pair is ignored.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   localparam int BASE_W = 16;

   typedef enum logic [1:0] {
      LK_CLOSED = 2'd0,
      LK_HALF   = 2'd1,
      LK_OPEN   = 2'd2
   } lock_state_t;

   localparam logic [7:0] KEY_ON       = 8'h87;
   localparam logic [7:0] KEY_OFF      = 8'hAA;

   localparam logic [7:0] RG_DEVSEL    = 8'h07;
   localparam logic [7:0] RG_CHIP_HI   = 8'h20;
   localparam logic [7:0] RG_CHIP_LO   = 8'h21;
   localparam logic [7:0] RG_VEND_HI   = 8'h23;
   localparam logic [7:0] RG_VEND_LO   = 8'h24;
   localparam logic [7:0] RG_ENABLE    = 8'h30;
   localparam logic [7:0] RG_BASE_HI   = 8'h60;
   localparam logic [7:0] RG_BASE_LO   = 8'h61;
   localparam logic [7:0] RG_IRQ       = 8'h70;

   function automatic logic is_bank_reg(input logic [7:0] idx);
      return (idx == RG_ENABLE) || (idx == RG_BASE_HI) ||
             (idx == RG_BASE_LO) || (idx == RG_IRQ);
   endfunction
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
   parameter int          ADDR_W    = 16,
   parameter logic [15:0] PRI_INDEX = 16'h002E,
   parameter logic [15:0] PRI_DATA  = 16'h002F,
   parameter logic [15:0] ALT_INDEX = 16'h004E,
   parameter logic [15:0] ALT_DATA  = 16'h004F
) (
   input  logic              strap_alt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              wr_en,
   input  logic              rd_en,
   output logic              idx_wr,
   output logic              idx_rd,
   output logic              dat_wr,
   output logic              dat_rd
);
   localparam logic [ADDR_W-1:0] P_I = PRI_INDEX[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] P_D = PRI_DATA[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_I = ALT_INDEX[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] A_D = ALT_DATA[ADDR_W-1:0];

   logic hit_idx, hit_dat;

   always_comb begin
      hit_idx = strap_alt ? (bus_addr == A_I) : (bus_addr == P_I);
      hit_dat = strap_alt ? (bus_addr == A_D) : (bus_addr == P_D);
   end

   assign idx_wr = wr_en & hit_idx;
   assign idx_rd = rd_en & hit_idx;
   assign dat_wr = wr_en & hit_dat;
   assign dat_rd = rd_en & hit_dat;
endmodule

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
   import cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       cfg_open,
   output logic [7:0] idx_q
);
   lock_state_t st_q, st_d;
   logic [7:0]  idx_d;

   always_comb begin
      st_d  = st_q;
      idx_d = idx_q;
      if (idx_wr) begin
         unique case (st_q)
            LK_CLOSED: if (wdata == KEY_ON) st_d = LK_HALF;
            LK_HALF:   st_d = (wdata == KEY_ON) ? LK_OPEN : LK_CLOSED;
            LK_OPEN: begin
               if (wdata == KEY_OFF) st_d  = LK_CLOSED;
               else                  idx_d = wdata;
            end
            default:   st_d = LK_CLOSED;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= LK_CLOSED;
         idx_q <= 8'h00;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
      end
   end

   assign cfg_open = (st_q == LK_OPEN);
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
   import cfg_pkg::*;
#(
   parameter int IRQ_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic [7:0]        idx,
   input  logic [7:0]        wdata,
   output logic              en_q,
   output logic [BASE_W-1:0] base_q,
   output logic [IRQ_W-1:0]  irq_q,
   output logic [7:0]        rd_val
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         base_q <= '0;
         irq_q  <= '0;
      end else if (wr_go) begin
         case (idx)
            RG_ENABLE:  en_q          <= wdata[0];
            RG_BASE_HI: base_q[15:8]  <= wdata;
            RG_BASE_LO: base_q[7:0]   <= wdata;
            RG_IRQ:     irq_q         <= wdata[IRQ_W-1:0];
            default:    ;
         endcase
      end
   end

   always_comb begin
      case (idx)
         RG_ENABLE:  rd_val = {7'b0, en_q};
         RG_BASE_HI: rd_val = base_q[15:8];
         RG_BASE_LO: rd_val = base_q[7:0];
         RG_IRQ:     rd_val = 8'(irq_q);
         default:    rd_val = 8'h00;
      endcase
   end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
   import cfg_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          NUM_DEV   = 4,
   parameter int          IRQ_W     = 4,
   parameter logic [15:0] CHIP_ID   = 16'h5A21,
   parameter logic [15:0] VENDOR_ID = 16'h1C34,
   parameter logic [15:0] PRI_INDEX = 16'h002E,
   parameter logic [15:0] PRI_DATA  = 16'h002F,
   parameter logic [15:0] ALT_INDEX = 16'h004E,
   parameter logic [15:0] ALT_DATA  = 16'h004F
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      strap_alt,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic                      wr_en,
   input  logic                      rd_en,
   input  logic [7:0]                wdata,
   output logic [7:0]                rdata,
   output logic [NUM_DEV-1:0]        dev_enable,
   output logic [NUM_DEV*BASE_W-1:0] dev_base,
   output logic [NUM_DEV*IRQ_W-1:0]  dev_irq
);
   generate
      if (NUM_DEV < 1 || NUM_DEV > 16) begin : g_bad_dev
         $error("cfg_port_ctrl: NUM_DEV must be 1..16");
      end
      if (IRQ_W < 1 || IRQ_W > 8) begin : g_bad_irq
         $error("cfg_port_ctrl: IRQ_W must be 1..8");
      end
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr
         $error("cfg_port_ctrl: ADDR_W must be 8..16");
      end
   endgenerate

   logic       idx_wr, idx_rd, dat_wr, dat_rd;
   logic       cfg_open;
   logic [7:0] idx_q;
   logic [7:0] dev_sel;
   logic [7:0] bank_rd [NUM_DEV];
   logic [7:0] bank_pick, rd_mux;

   cfg_port_decode #(
      .ADDR_W(ADDR_W), .PRI_INDEX(PRI_INDEX), .PRI_DATA(PRI_DATA),
      .ALT_INDEX(ALT_INDEX), .ALT_DATA(ALT_DATA)
   ) u_dec (
      .strap_alt(strap_alt), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
      .idx_wr(idx_wr), .idx_rd(idx_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
   );

   cfg_unlock_fsm u_lock (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(wdata),
      .cfg_open(cfg_open), .idx_q(idx_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                                       dev_sel <= 8'h00;
      else if (dat_wr && cfg_open && idx_q == RG_DEVSEL) dev_sel <= wdata;
   end

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
      logic go;
      assign go = dat_wr && cfg_open && (dev_sel == 8'(d));
      cfg_dev_bank #(.IRQ_W(IRQ_W)) u_bank (
         .clk(clk), .rst_n(rst_n), .wr_go(go), .idx(idx_q), .wdata(wdata),
         .en_q(dev_enable[d]),
         .base_q(dev_base[d*BASE_W +: BASE_W]),
         .irq_q(dev_irq[d*IRQ_W +: IRQ_W]),
         .rd_val(bank_rd[d])
      );
   end

   always_comb begin
      bank_pick = 8'hFF;
      for (int d = 0; d < NUM_DEV; d++)
         if (dev_sel == 8'(d)) bank_pick = bank_rd[d];
   end

   always_comb begin
      case (idx_q)
         RG_DEVSEL:  rd_mux = dev_sel;
         RG_CHIP_HI: rd_mux = CHIP_ID[15:8];
         RG_CHIP_LO: rd_mux = CHIP_ID[7:0];
         RG_VEND_HI: rd_mux = VENDOR_ID[15:8];
         RG_VEND_LO: rd_mux = VENDOR_ID[7:0];
         default:    rd_mux = is_bank_reg(idx_q) ? bank_pick : 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    rdata <= 8'hFF;
      else if (rd_en) begin
         if (idx_rd && cfg_open)      rdata <= idx_q;
         else if (dat_rd && cfg_open) rdata <= rd_mux;
         else                         rdata <= 8'hFF;
      end
   end
endmodule

// File: rtl/cfg_port_ctrl_chk.sv
module cfg_port_ctrl_chk #(
   parameter int          ADDR_W    = 16,
   parameter int          NUM_DEV   = 4,
   parameter int          IRQ_W     = 4,
   parameter logic [15:0] PRI_INDEX = 16'h002E,
   parameter logic [15:0] PRI_DATA  = 16'h002F,
   parameter logic [15:0] ALT_INDEX = 16'h004E,
   parameter logic [15:0] ALT_DATA  = 16'h004F
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      strap_alt,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic                      wr_en,
   input logic                      rd_en,
   input logic [7:0]                wdata,
   input logic [7:0]                rdata,
   input logic                      cfg_open,
   input logic [NUM_DEV-1:0]        dev_enable,
   input logic [NUM_DEV*16-1:0]     dev_base,
   input logic [NUM_DEV*IRQ_W-1:0]  dev_irq
);
   logic on_idx, on_any;
   assign on_idx = strap_alt ? (bus_addr == ALT_INDEX[ADDR_W-1:0])
                             : (bus_addr == PRI_INDEX[ADDR_W-1:0]);
   assign on_any = on_idx || (strap_alt ? (bus_addr == ALT_DATA[ADDR_W-1:0])
                                        : (bus_addr == PRI_DATA[ADDR_W-1:0]));

   // R2
   key_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(wr_en && on_idx && wdata == 8'h87));

   // R3
   key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && wr_en && on_idx && wdata == 8'hAA) |=> !cfg_open);

   // R3
   closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && rd_en) |=> (rdata == 8'hFF));

   // R10
   foreign_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !on_any) |=> (rdata == 8'hFF));

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   // R6
   bank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(dev_enable) && $stable(dev_base) && $stable(dev_irq)));
endmodule

bind cfg_port_ctrl cfg_port_ctrl_chk #(
   .ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV), .IRQ_W(IRQ_W),
   .PRI_INDEX(PRI_INDEX), .PRI_DATA(PRI_DATA),
   .ALT_INDEX(ALT_INDEX), .ALT_DATA(ALT_DATA)
) u_chk (
   .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .bus_addr(bus_addr),
   .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
   .cfg_open(cfg_open), .dev_enable(dev_enable), .dev_base(dev_base),
   .dev_irq(dev_irq)
);

// File: tb/sim_cfg_port_ctrl.sv
module sim_cfg_port_ctrl;
   localparam int NDEV = 4;
   localparam int IRQW = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             strap_alt = 1'b0;
   logic [15:0]      bus_addr = 16'h0;
   logic             wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]       wdata = 8'h0;
   logic [7:0]       rdata;
   logic [NDEV-1:0]  dev_enable;
   logic [NDEV*16-1:0]   dev_base;
   logic [NDEV*IRQW-1:0] dev_irq;

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cfg_port_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .bus_addr(bus_addr),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .dev_enable(dev_enable), .dev_base(dev_base), .dev_irq(dev_irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   // entry: {op[1:0], byte[7:0], expected[7:0], requirement number[7:0]}
   // op 0 index write, 1 data write, 2 index read, 3 data read
   localparam int N = 62;
   localparam logic [25:0] TBL [N] = '{
      {2'd0, 8'h87, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'hFF, 8'd2},  // R2 lone key keeps it closed
      {2'd0, 8'h87, 8'h00, 8'd0},
      {2'd2, 8'h00, 8'h00, 8'd4},  // R4 index reads back
      {2'd0, 8'h20, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h5A, 8'd7},  // R7 chip hi
      {2'd0, 8'h21, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h21, 8'd7},  // R7 chip lo
      {2'd0, 8'h23, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h1C, 8'd7},  // R7 vendor hi
      {2'd0, 8'h24, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h34, 8'd7},  // R7 vendor lo
      {2'd0, 8'h20, 8'h00, 8'd0},
      {2'd1, 8'h00, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h5A, 8'd7},  // R7 write ignored
      {2'd0, 8'h07, 8'h00, 8'd0},
      {2'd1, 8'h01, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h01, 8'd5},  // R5 device select readback
      {2'd0, 8'h60, 8'h00, 8'd0},
      {2'd1, 8'h12, 8'h00, 8'd0},
      {2'd0, 8'h61, 8'h00, 8'd0},
      {2'd1, 8'h34, 8'h00, 8'd0},
      {2'd0, 8'h70, 8'h00, 8'd0},
      {2'd1, 8'hFB, 8'h00, 8'd0},
      {2'd0, 8'h30, 8'h00, 8'd0},
      {2'd1, 8'h01, 8'h00, 8'd0},
      {2'd0, 8'h60, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h12, 8'd6},  // R6 base hi
      {2'd0, 8'h70, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h0B, 8'd6},  // R6 irq truncated
      {2'd0, 8'h30, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h01, 8'd6},  // R6 enable
      {2'd0, 8'h61, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h34, 8'd4},  // R4 base lo via index
      {2'd0, 8'h07, 8'h00, 8'd0},
      {2'd1, 8'h02, 8'h00, 8'd0},
      {2'd0, 8'h60, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h00, 8'd5},  // R5 other bank untouched
      {2'd0, 8'h07, 8'h00, 8'd0},
      {2'd1, 8'h05, 8'h00, 8'd0},
      {2'd0, 8'h60, 8'h00, 8'd0},
      {2'd1, 8'h99, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'hFF, 8'd9},  // R9 out-of-range reads FF
      {2'd0, 8'h07, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h05, 8'd5},  // R5 readback of any number
      {2'd1, 8'h01, 8'h00, 8'd0},
      {2'd0, 8'h60, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h12, 8'd9},  // R9 write did not leak
      {2'd0, 8'h33, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h00, 8'd10}, // R10 unmapped reads 00
      {2'd0, 8'h60, 8'h00, 8'd0},
      {2'd0, 8'hAA, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'hFF, 8'd3},  // R3 closed data read
      {2'd2, 8'h00, 8'hFF, 8'd3},  // R3 closed index read
      {2'd1, 8'h00, 8'h00, 8'd0},
      {2'd0, 8'h87, 8'h00, 8'd0},
      {2'd0, 8'h55, 8'h00, 8'd0},
      {2'd0, 8'h87, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'hFF, 8'd2},  // R2 interrupted sequence restarts
      {2'd0, 8'h87, 8'h00, 8'd0},
      {2'd3, 8'h00, 8'h12, 8'd3},  // R3 closed write ignored, R4 index kept
      {2'd2, 8'h00, 8'h60, 8'd4}   // R4 index kept across lock
   };

   initial begin
      logic [7:0] rv;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rdata", rdata, 8'hFF);
      check("R1 enable", dev_enable, '0);
      check("R1 base", dev_base, '0);
      check("R1 irq", dev_irq, '0);
      rst_n = 1'b1;

      for (int i = 0; i < N; i++) begin
         logic [25:0] e;
         e = TBL[i];
         case (e[25:24])
            2'd0: bus_wr(16'h002E, e[23:16]);
            2'd1: bus_wr(16'h002F, e[23:16]);
            2'd2: begin bus_rd(16'h002E, rv); check($sformatf("R%0d row %0d", e[7:0], i), rv, e[15:8]); end
            default: begin bus_rd(16'h002F, rv); check($sformatf("R%0d row %0d", e[7:0], i), rv, e[15:8]); end
         endcase
      end

      // R6 output pins
      check("R6 dev_enable", dev_enable, 4'b0010);
      check("R6 base dev1", dev_base[31:16], 16'h1234);
      check("R6 irq dev1", dev_irq[7:4], 4'hB);
      check("R6 base dev2", dev_base[47:32], 16'h0000);

      // R8 strap selects the alternate pair
      strap_alt = 1'b1;
      bus_rd(16'h002F, rv);  check("R8 inactive pair read", rv, 8'hFF);
      bus_rd(16'h004F, rv);  check("R8 alternate data read", rv, 8'h12);
      bus_wr(16'h002E, 8'hAA);
      bus_rd(16'h004F, rv);  check("R8 key on inactive pair ignored", rv, 8'h12);
      strap_alt = 1'b0;

      // R10 timing and foreign address
      bus_rd(16'h002F, rv);  check("R10 read next cycle", rv, 8'h12);
      @(negedge clk);        check("R10 rdata holds", rdata, 8'h12);
      bus_rd(16'h0080, rv);  check("R10 foreign address", rv, 8'hFF);

      // R1 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 rdata after reset", rdata, 8'hFF);
      check("R1 enable after reset", dev_enable, '0);
      check("R1 base after reset", dev_base, '0);
      rst_n = 1'b1;
      bus_rd(16'h002F, rv);  check("R1 closed after reset", rv, 8'hFF);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule